// File: doc/BRIEF.md
# Dual Two-Phase Interval Timer with Watchdog

This peripheral holds two independent interval channels on a small 32-bit register bus. Each channel splits its period into two back-to-back countdowns. A first-phase count runs first, then a second-phase count runs. When the second phase ends, the channel pulses its interrupt line for one cycle, reloads both phases and starts the next period.

Software programs a channel while it is stopped. It clears the channel's enable bit, writes the two count registers and sets the enable bit again. Setting the bit starts the period from the first phase with the new values. Reading a count register returns what is left of that phase, so the ticks left in the period are the sum of the two reads.

Channel 0 can also serve as a system watchdog. When the low byte of its first-phase register holds the key value, the rest of that register gives the watchdog interval. On expiry the block raises a reset request that stays high until the block itself is reset.

Top module: `duo_phase_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads 0, both channels are stopped, and irq, pulse and wdog_rst_req are all 0.
- R2: Registers are selected by a 3-bit word index (byte offset = 4 × index). Index 0 is control: bit 0 enables channel 0 and bit 1 enables channel 1. Index 1 is the channel 1 first-phase count, index 2 the channel 0 first-phase count, index 3 the channel 1 second-phase count and index 4 the channel 0 second-phase count. A write takes effect at the clock edge that samples it.
- R3: Indices 5 to 7 read as 0, and writes to them change no register.
- R4: A channel enabled at edge k with first-phase count T and second-phase count P drives its irq bit high for exactly one cycle: the cycle after edge k+T+P. This repeats every T+P cycles.
- R5: A phase loaded with 0 lasts one cycle, so counts of 0/0 give an irq every 2 cycles.
- R6: A running, non-watchdog channel drives its pulse bit high in the cycles after edges k+T … k+T+P−1 of each period, and low otherwise.
- R7: While the channel is stopped, a count register reads its written value. While the channel runs in the first phase, the first-phase register reads the cycles left in that phase and the second-phase register reads P. In the second phase, the first-phase register reads 0 and the second-phase register reads the cycles left.
- R8: Clearing an enable bit stops the channel: no irq and a low pulse. Setting the bit from 0 restarts the channel from the first phase with the current counts. Writing 1 to a bit that is already 1 does not restart the channel.
- R9: A count register written while its channel runs is used the next time that phase loads. The phase in progress is not affected.
- R10: When bits 7:0 of the channel 0 first-phase register equal 0xFF, channel 0 is in watchdog mode. Enabled at edge k, it raises wdog_rst_req at edge k+W, where W = bits 31:8 (0 counts as 1). In this mode channel 0 never raises irq[0] and keeps pulse[0] low. wdog_rst_req stays high, even after disable, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 2 | One-cycle end-of-period strobe per channel |
| pulse | output | 2 | High during each channel's second phase |
| wdog_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench counts edges from the enabling write and probes the cycles on either side of each phase boundary. An off-by-one in reload or phase switching would move the irq strobe or the pulse edges by a cycle.

Counts of zero are driven to show that each phase still lasts one cycle. A design that let a zero count wrap would go silent for billions of cycles.

A redundant enable write and a mid-period count write are issued. A design that restarted on any control write, or that loaded new counts into the running phase, would shift the next strobe.

The watchdog is checked at the exact expiry cycle, after a disable, and across a reset. A request that cleared on disable, or that arrived one cycle off, would be reported.

// File: rtl/dpt_pkg.sv
// Shared constants and types for the dual two-phase timer.
// Assumes a 3-bit word index on the register bus.
package dpt_pkg;
    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned ADDR_W   = 3;
    localparam logic [7:0]  WDOG_KEY = 8'hFF;

    localparam logic [ADDR_W-1:0] IDX_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_T1_A  = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_T0_A  = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_T1_B  = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_T0_B  = 3'd4;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;
endpackage

// File: rtl/dpt_regfile.sv
// Register file and bus decode for the dual two-phase timer.
// Holds the enable bits and the loaded counts of both channels, generates
// a start strobe when an enable bit goes from 0 to 1, and muxes read data.
// Assumes one access per cycle; reads are combinational.
module dpt_regfile
    import dpt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel_i,
    input  logic                          bus_we_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [CNT_W-1:0]              bus_wdata_i,
    output logic [CNT_W-1:0]              bus_rdata_o,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_a_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_b_i,
    output logic [NUM_CH-1:0]             en_o,
    output logic [NUM_CH-1:0]             start_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]  ld_a_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]  ld_b_o
);
    logic wr;
    logic wr_ctrl;

    assign wr      = bus_sel_i && bus_we_i;
    assign wr_ctrl = wr && (bus_addr_i == IDX_CTRL);

    // Start strobe: an enable bit written from 0 to 1.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            start_o[c] = wr_ctrl && bus_wdata_i[c] && !en_o[c];
        end
    end

    // Register writes, decoded by word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= '0;
            ld_a_o <= '0;
            ld_b_o <= '0;
        end else if (wr) begin
            case (bus_addr_i)
                IDX_CTRL: en_o      <= bus_wdata_i[NUM_CH-1:0];
                IDX_T1_A: ld_a_o[1] <= bus_wdata_i;
                IDX_T0_A: ld_a_o[0] <= bus_wdata_i;
                IDX_T1_B: ld_b_o[1] <= bus_wdata_i;
                IDX_T0_B: ld_b_o[0] <= bus_wdata_i;
                default:  ;
            endcase
        end
    end

    // Read mux; unused indices return zero.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            case (bus_addr_i)
                IDX_CTRL: bus_rdata_o[NUM_CH-1:0] = en_o;
                IDX_T1_A: bus_rdata_o = rd_a_i[1];
                IDX_T0_A: bus_rdata_o = rd_a_i[0];
                IDX_T1_B: bus_rdata_o = rd_b_i[1];
                IDX_T0_B: bus_rdata_o = rd_b_i[0];
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    // R2: a control write lands in the enable bits at the next edge.
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (en_o == $past(bus_wdata_i[NUM_CH-1:0])));

    // R3: writes to unused indices leave every register unchanged.
    a_r3_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr_i > IDX_T0_B) |=> ($stable(en_o) && $stable(ld_a_o) && $stable(ld_b_o)));
endmodule

// File: rtl/dpt_channel.sv
// One two-phase countdown channel. On start it loads the first-phase count,
// counts it down, then loads and counts the second-phase count. At the end
// of the second phase it strobes irq and reloads. A zero count lasts one cycle.
// With WDOG_OK set, watchdog mode counts only the first phase (interval in
// bits above the low byte) and then sets a sticky reset request.
module dpt_channel
    import dpt_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter bit          WDOG_OK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             wdog_i,
    input  logic [CNT_W-1:0] ld_a_i,
    input  logic [CNT_W-1:0] ld_b_i,
    output logic             irq_o,
    output logic             pulse_o,
    output logic             rst_req_o,
    output logic [CNT_W-1:0] rd_a_o,
    output logic [CNT_W-1:0] rd_b_o
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             done;
    logic             wdog_mode;
    logic [CNT_W-1:0] raw_a;
    logic [CNT_W-1:0] eff_a;
    logic [CNT_W-1:0] eff_b;

    // Watchdog mode exists only on the channel built with WDOG_OK.
    generate
        if (WDOG_OK) begin : g_wdog
            assign wdog_mode = wdog_i;
        end else begin : g_plain
            assign wdog_mode = 1'b0;
        end
    endgenerate

    // Effective phase lengths; zero stretches to one cycle.
    always_comb begin
        raw_a = wdog_mode ? (ld_a_i >> 8) : ld_a_i;
        eff_a = (raw_a == '0) ? CNT_W'(1) : raw_a;
        eff_b = (ld_b_i == '0) ? CNT_W'(1) : ld_b_i;
    end

    // Phase sequencing, reload, irq strobe and watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_FIRST;
            cnt       <= '0;
            done      <= 1'b0;
            irq_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (start_i) begin
                phase <= PH_FIRST;
                cnt   <= eff_a;
                done  <= 1'b0;
            end else if (en_i && !done) begin
                if (cnt == CNT_W'(1)) begin
                    if (phase == PH_FIRST) begin
                        if (wdog_mode) begin
                            rst_req_o <= 1'b1;
                            done      <= 1'b1;
                            cnt       <= '0;
                        end else begin
                            phase <= PH_SECOND;
                            cnt   <= eff_b;
                        end
                    end else begin
                        irq_o <= 1'b1;
                        phase <= PH_FIRST;
                        cnt   <= eff_a;
                    end
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    // Remaining-count view for software reads.
    always_comb begin
        if (!en_i) begin
            rd_a_o = ld_a_i;
            rd_b_o = ld_b_i;
        end else if (phase == PH_FIRST) begin
            rd_a_o = cnt;
            rd_b_o = ld_b_i;
        end else begin
            rd_a_o = '0;
            rd_b_o = cnt;
        end
    end

    assign pulse_o = en_i && (phase == PH_SECOND) && !wdog_mode;

    // R4: irq is a single-cycle strobe (period is at least 2 cycles).
    a_r4_irq_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R4: irq only follows a running second phase.
    a_r4_irq_after_second: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_i && phase == PH_SECOND));

    // R5: a running channel never holds a zero count.
    a_r5_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !done && !start_i) |-> (cnt != '0));

    // R10: the reset request is sticky.
    a_r10_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);

    // R10: the reset request only rises out of watchdog mode.
    a_r10_rst_from_wdog: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(wdog_mode));
endmodule

// File: rtl/duo_phase_timer.sv
// Top of the dual two-phase timer. Ties the register file to two channels;
// channel 0 is built with watchdog capability, selected by a key value in the
// low byte of its first-phase register.
// Assumes CNT_W equals the bus width and is at least 9.
module duo_phase_timer
    import dpt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic [1:0]       irq,
    output logic [1:0]       pulse,
    output logic             wdog_rst_req
);
    logic [NUM_CH-1:0][CNT_W-1:0] ld_a;
    logic [NUM_CH-1:0][CNT_W-1:0] ld_b;
    logic [NUM_CH-1:0][CNT_W-1:0] rd_a;
    logic [NUM_CH-1:0][CNT_W-1:0] rd_b;
    logic [NUM_CH-1:0]            en;
    logic [NUM_CH-1:0]            start;
    logic [NUM_CH-1:0]            rst_req;
    logic                         wdog_sel;

    assign wdog_sel     = (ld_a[0][7:0] == WDOG_KEY);
    assign wdog_rst_req = |rst_req;

    dpt_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .rd_a_i      (rd_a),
        .rd_b_i      (rd_b),
        .en_o        (en),
        .start_o     (start),
        .ld_a_o      (ld_a),
        .ld_b_o      (ld_b)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dpt_channel #(.CNT_W(CNT_W), .WDOG_OK(c == 0)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .en_i      (en[c]),
                .start_i   (start[c]),
                .wdog_i    (wdog_sel),
                .ld_a_i    (ld_a[c]),
                .ld_b_i    (ld_b[c]),
                .irq_o     (irq[c]),
                .pulse_o   (pulse[c]),
                .rst_req_o (rst_req[c]),
                .rd_a_o    (rd_a[c]),
                .rd_b_o    (rd_b[c])
            );
        end
    endgenerate
endmodule

// File: tb/duo_phase_timer_bench.sv
`timescale 1ns/100ps
module duo_phase_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    logic [1:0]  pulse;
    logic        wdog_rst_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    duo_phase_timer u_duo_phase_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .pulse(pulse), .wdog_rst_req(wdog_rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called just after a negedge; the write lands at the next posedge.
    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = idx; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = idx;
        #0.2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), d);
            check("R1 reg zero", d, 0);
        end
        check("R1 irq", {30'd0, irq}, 0);
        check("R1 pulse", {30'd0, pulse}, 0);
        check("R1 wdog", {31'd0, wdog_rst_req}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(3'd1, 32'h1111_0001);
        wr(3'd2, 32'h2222_0002);
        wr(3'd3, 32'h3333_0003);
        wr(3'd4, 32'h4444_0004);
        wr(3'd5, 32'hDEAD_BEEF);
        wr(3'd6, 32'hDEAD_BEEF);
        wr(3'd7, 32'hDEAD_BEEF);
        rd(3'd1, d); check("R2 ch1 first", d, 32'h1111_0001);
        rd(3'd2, d); check("R2 ch0 first", d, 32'h2222_0002);
        rd(3'd3, d); check("R2 ch1 second", d, 32'h3333_0003);
        rd(3'd4, d); check("R2 ch0 second", d, 32'h4444_0004);
        rd(3'd0, d); check("R3 ctrl untouched", d, 0);
        for (int i = 5; i < 8; i++) begin
            rd(3'(i), d);
            check("R3 unused reads zero", d, 0);
        end
    endtask

    task automatic t_period();
        logic [31:0] da, db;
        wr(3'd1, 32'd3);
        wr(3'd3, 32'd2);
        wr(3'd0, 32'd2);
        for (int m = 0; m < 12; m++) begin
            int ph = m % 5;
            rd(3'd1, da);
            rd(3'd3, db);
            #0.2;
            check("R4 ch1 irq", {31'd0, irq[1]}, (m > 0 && ph == 0) ? 1 : 0);
            check("R4 ch0 quiet", {31'd0, irq[0]}, 0);
            check("R6 ch1 pulse", {31'd0, pulse[1]}, (ph >= 3) ? 1 : 0);
            check("R7 first remain", da, (ph < 3) ? 32'(3 - ph) : 0);
            check("R7 second remain", db, (ph < 3) ? 32'd2 : 32'(2 - (ph - 3)));
            @(negedge clk);
        end
    endtask

    task automatic t_zero_counts();
        wr(3'd2, 32'd0);
        wr(3'd4, 32'd0);
        wr(3'd0, 32'd1);
        for (int m = 0; m < 8; m++) begin
            #0.2;
            check("R5 ch0 irq every 2", {31'd0, irq[0]}, (m > 0 && m % 2 == 0) ? 1 : 0);
            check("R6 ch0 pulse", {31'd0, pulse[0]}, (m % 2 == 1) ? 1 : 0);
            @(negedge clk);
        end
        wr(3'd0, 32'd0);
    endtask

    task automatic t_stop_restart();
        logic [31:0] d;
        wr(3'd1, 32'd3);
        wr(3'd3, 32'd2);
        wr(3'd0, 32'd2);
        @(negedge clk);
        @(negedge clk);
        wr(3'd0, 32'd0);
        for (int m = 0; m < 8; m++) begin
            #0.2;
            check("R8 stopped irq", {31'd0, irq[1]}, 0);
            check("R8 stopped pulse", {31'd0, pulse[1]}, 0);
            @(negedge clk);
        end
        rd(3'd1, d); check("R7 stopped first reads load", d, 3);
        rd(3'd3, d); check("R7 stopped second reads load", d, 2);
        wr(3'd1, 32'd4);
        wr(3'd3, 32'd1);
        wr(3'd0, 32'd2);
        for (int m = 0; m < 7; m++) begin
            #0.2;
            check("R8 restart new counts", {31'd0, irq[1]}, (m == 5) ? 1 : 0);
            @(negedge clk);
        end
        wr(3'd0, 32'd0);
        wr(3'd0, 32'd2);
        @(negedge clk);
        wr(3'd0, 32'd2);
        for (int m = 2; m < 7; m++) begin
            #0.2;
            check("R8 redundant enable no restart", {31'd0, irq[1]}, (m == 5) ? 1 : 0);
            @(negedge clk);
        end
        wr(3'd0, 32'd0);
    endtask

    task automatic t_live_write();
        wr(3'd1, 32'd2);
        wr(3'd3, 32'd2);
        wr(3'd0, 32'd2);
        @(negedge clk);
        @(negedge clk);
        wr(3'd1, 32'd4);
        for (int m = 3; m < 12; m++) begin
            #0.2;
            check("R9 live write next load", {31'd0, irq[1]}, (m == 4 || m == 10) ? 1 : 0);
            @(negedge clk);
        end
        wr(3'd0, 32'd0);
    endtask

    task automatic t_watchdog();
        logic [31:0] d;
        wr(3'd2, 32'h0000_0AFF);
        wr(3'd0, 32'd1);
        for (int m = 0; m < 13; m++) begin
            #0.2;
            check("R10 wdog expiry", {31'd0, wdog_rst_req}, (m >= 10) ? 1 : 0);
            check("R10 no irq0", {31'd0, irq[0]}, 0);
            check("R10 no pulse0", {31'd0, pulse[0]}, 0);
            @(negedge clk);
        end
        wr(3'd0, 32'd0);
        repeat (3) @(negedge clk);
        #0.2;
        check("R10 sticky after disable", {31'd0, wdog_rst_req}, 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #0.2;
        check("R1 reset clears wdog", {31'd0, wdog_rst_req}, 0);
        rd(3'd2, d); check("R1 reset clears count", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_regmap();
        t_period();
        wr(3'd0, 32'd0);
        t_zero_counts();
        t_stop_restart();
        t_live_write();
        t_watchdog();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule